// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is a cycle-based model of a 512-byte non-volatile memory that answers on a four-wire serial bus as a slave. It also has a write-guard input and an active-low pause input. All bus inputs are sampled on the system clock `clk`. The serial clock idles low. The block latches incoming bits on its falling edge and launches outgoing bits on its rising edge, most significant bit first, in whole 8-bit words.

A host reads the array from any address and keeps clocking to stream successive bytes. To program, the host first sets the write-enable latch. It then sends a write frame with one to four data bytes that belong to one aligned 4-byte page. Programming starts when the select line is released. The programming cycle is timed by an internal counter of `PROG_CYCLES` clocks. During that cycle only the status byte can be read, and it carries a busy flag. Two status bits choose how much of the array, counted from the top address down, refuses programming. The write-guard input must be high for any programming to start. The pause input freezes a frame part way through without losing its bit position.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset every array byte reads 0xFF and the status byte is 0x00. `serDout` stays low whenever `chipSelN` is high.
- R2: A frame starts with `chipSelN` falling. Bits are taken from `serDin` on falling `serClk` edges and placed on `serDout` after rising edges, MSB first, eight per word.
- R3: A write frame has these parts in order:
  - opcode 0x02, with address bit 8 carried in opcode bit 3;
  - an address byte holding address bits 7..0;
  - one or more data bytes.
  Programming starts only if `chipSelN` rises at a word boundary after at least one data byte. Otherwise the frame is discarded.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. A write or status write sent while the latch is clear changes nothing.
- R5: A program cycle lasts `PROG_CYCLES` clocks. When it ends the write-enable latch is cleared.
- R6: If `wrAllow` is low when `chipSelN` rises, no program cycle starts and the write-enable latch keeps its value.
- R7: While `pauseN` is low and the block is selected, `serClk` edges and `serDin` are ignored and the bit position is kept.
- R8: Opcode 0x05 returns the status byte in every following word, including during a program cycle. The status byte is laid out as follows:
  - bit 0: busy;
  - bit 1: write-enable latch;
  - bits 3:2: protection level;
  - all other bits: 0.
- R9: In a write frame, data byte j goes to the page slot (start + j) mod 4 of the page that holds the start address. A later byte for the same slot replaces an earlier one.
- R10: A read frame uses opcode 0x03, with address bit 8 carried in opcode bit 3, followed by an address byte. It returns successive bytes, and the address wraps from 0x1FF to 0x000.
- R11: Opcode 0x01 followed by a data byte loads data bits 3:2 into the protection level. It needs the write-enable latch and `wrAllow`, and it takes one program cycle.
- R12: The protection level decides which writes are refused. A refused write starts no cycle and keeps the write-enable latch set:
  - 00: no address is protected;
  - 01: addresses 0x180 and above are protected;
  - 10: addresses 0x100 and above are protected;
  - 11: every address is protected.
- R13: While busy, every opcode other than 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| chipSelN | input | 1 | Active-low device select |
| serClk | input | 1 | Serial bit clock, idles low |
| serDin | input | 1 | Serial data from the host |
| serDout | output | 1 | Serial data to the host |
| wrAllow | input | 1 | High permits programming |
| pauseN | input | 1 | Active-low freeze of the current frame |

## Verification
A wrong bit counter or a wrong frame state shows within the next word. The read data comes out shifted, or the status word carries the wrong latch or busy value. A wrong protection decision or a wrong write-enable latch is seen in the status byte read right after deselect, because busy is set or clear at once. A wrong page index or a wrong commit is seen only after the program cycle, when the affected bytes are read back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W     = 9;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 4;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int A8_BIT     = 3;

  localparam logic [7:0] OP_SETWEL = 8'h06;
  localparam logic [7:0] OP_CLRWEL = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RD, ST_WR, ST_STR, ST_STW, ST_SKIP
  } frameState_t;

  typedef struct packed {
    logic outEn;
    logic loadMem;
    logic loadStat;
    logic shiftOut;
    logic bufClr;
    logic bufPut;
    logic commit;
  } eepStrobes_t;

  function automatic logic isProtected(input logic [1:0] lvl,
                                       input logic [ADDR_W-1:0] a);
    case (lvl)
      2'b01:   return a[ADDR_W-1:ADDR_W-2] == 2'b11;
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              serClk,
  input  logic              serDin,
  input  logic              wrAllow,
  input  logic              pauseN,
  output eepStrobes_t       strb,
  output logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] bufIdx,
  output logic [7:0]        rxByte,
  output logic [7:0]        statusByte
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic sclkQ, csQ, active, sRise, sFall, csRise, byteDone, startOk;
  logic [2:0] bitCnt;
  logic [6:0] inSh;
  logic [7:0] byteIn;
  frameState_t state;
  logic wel, busy, progStat, gotData, hiAddr, isRead;
  logic [1:0] bp, newBp;
  logic [CNT_W-1:0] cnt;
  logic [PAGE_W-1:0] wrIdx;

  assign active   = !chipSelN && pauseN;
  assign sRise    = active && serClk && !sclkQ;
  assign sFall    = active && !serClk && sclkQ;
  assign csRise   = chipSelN && !csQ;
  assign byteIn   = {inSh, serDin};
  assign byteDone = sFall && (bitCnt == 3'd7);
  assign startOk  = wel && wrAllow && (bitCnt == 3'd0) && !busy;

  assign rxByte     = byteIn;
  assign bufIdx     = wrIdx;
  assign statusByte = {4'b0000, bp, wel, busy};

  always_comb begin
    strb          = '0;
    strb.outEn    = !chipSelN && (state == ST_RD || state == ST_STR);
    strb.loadMem  = sRise && (bitCnt == 3'd0) && (state == ST_RD);
    strb.loadStat = sRise && (bitCnt == 3'd0) && (state == ST_STR);
    strb.shiftOut = sRise && (bitCnt != 3'd0);
    strb.bufClr   = byteDone && (state == ST_ADDR);
    strb.bufPut   = byteDone && (state == ST_WR);
    strb.commit   = busy && (cnt == '0) && !progStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0; csQ <= 1'b1; bitCnt <= '0; inSh <= '0;
      state <= ST_OP; wel <= 1'b0; busy <= 1'b0; progStat <= 1'b0;
      gotData <= 1'b0; hiAddr <= 1'b0; isRead <= 1'b0;
      bp <= '0; newBp <= '0; cnt <= '0; wrIdx <= '0; addr <= '0;
    end else begin
      sclkQ <= serClk;
      csQ   <= chipSelN;
      if (csRise) begin
        if (startOk && state == ST_WR && gotData && !isProtected(bp, addr)) begin
          busy <= 1'b1; progStat <= 1'b0; cnt <= CNT_W'(PROG_CYCLES - 1);
        end else if (startOk && state == ST_STW && gotData) begin
          busy <= 1'b1; progStat <= 1'b1; cnt <= CNT_W'(PROG_CYCLES - 1);
        end
        state <= ST_OP; bitCnt <= '0; gotData <= 1'b0;
      end else if (sFall) begin
        bitCnt <= bitCnt + 3'd1;
        inSh   <= {inSh[5:0], serDin};
        if (bitCnt == 3'd7) begin
          case (state)
            ST_OP: begin
              if (byteIn == OP_RDSTAT)      state <= ST_STR;
              else if (busy)                state <= ST_SKIP;
              else if (byteIn == OP_SETWEL) begin wel <= 1'b1; state <= ST_SKIP; end
              else if (byteIn == OP_CLRWEL) begin wel <= 1'b0; state <= ST_SKIP; end
              else if (byteIn == OP_WRSTAT) state <= ST_STW;
              else if ((byteIn & ~(8'h1 << A8_BIT)) == OP_READ) begin
                hiAddr <= byteIn[A8_BIT]; isRead <= 1'b1; state <= ST_ADDR;
              end else if ((byteIn & ~(8'h1 << A8_BIT)) == OP_WRITE) begin
                hiAddr <= byteIn[A8_BIT]; isRead <= 1'b0; state <= ST_ADDR;
              end else state <= ST_SKIP;
            end
            ST_ADDR: begin
              addr  <= {hiAddr, byteIn};
              wrIdx <= byteIn[PAGE_W-1:0];
              state <= isRead ? ST_RD : ST_WR;
            end
            ST_RD:  addr <= addr + 1'b1;
            ST_WR:  begin wrIdx <= wrIdx + 1'b1; gotData <= 1'b1; end
            ST_STW: begin newBp <= byteIn[3:2]; gotData <= 1'b1; end
            default: ;
          endcase
        end
      end
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0; wel <= 1'b0;
          if (progStat) bp <= newBp;
        end else cnt <= cnt - 1'b1;
      end
    end
  end

  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel); // R5
  AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel)); // R4
  AST_PROG_NEEDS_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrAllow)); // R6
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseN && !chipSelN) |=> ($stable(bitCnt) || chipSelN)); // R7
  AST_BUSY_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_OP) |-> (state == ST_STR || state == ST_SKIP)); // R13
endmodule

// File: rtl/eep_data.sv
module eep_data
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eepStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] bufIdx,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        statusByte,
  output logic              serDout
);
  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [7:0] outReg;

  assign serDout = strb.outEn & outReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (bufValid[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g] <= '0; bufValid[g] <= 1'b0;
      end else if (strb.bufClr) begin
        bufValid[g] <= 1'b0;
      end else if (strb.bufPut && bufIdx == PAGE_W'(g)) begin
        pageBuf[g] <= rxByte; bufValid[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outReg <= '0;
    else if (strb.loadMem)  outReg <= mem[addr];
    else if (strb.loadStat) outReg <= statusByte;
    else if (strb.shiftOut) outReg <= {outReg[6:0], 1'b0};
  end

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (bufValid != '0)); // R3
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
  import eep_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSelN,
  input  logic serClk,
  input  logic serDin,
  output logic serDout,
  input  logic wrAllow,
  input  logic pauseN
);
  eepStrobes_t       strb;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] bufIdx;
  logic [7:0]        rxByte, statusByte;

  eep_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .serClk(serClk),
    .serDin(serDin), .wrAllow(wrAllow), .pauseN(pauseN), .strb(strb),
    .addr(addr), .bufIdx(bufIdx), .rxByte(rxByte), .statusByte(statusByte)
  );

  eep_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .bufIdx(bufIdx),
    .rxByte(rxByte), .statusByte(statusByte), .serDout(serDout)
  );
endmodule

// File: tb/tb_eep_spi_slave.sv
module tb_eep_spi_slave;
  localparam int PROG = 400;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic chipSelN = 1'b1, serClk = 1'b0, serDin = 1'b0, wrAllow = 1'b1, pauseN = 1'b1;
  logic serDout;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;
  logic [7:0] model [512];

  always #5 clk = ~clk;

  eep_spi_slave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .serClk(serClk),
    .serDin(serDin), .serDout(serDout), .wrAllow(wrAllow), .pauseN(pauseN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic r);
    @(negedge clk); serDin = b; serClk = 1'b1;
    repeat (HALF) @(negedge clk);
    r = serDout; serClk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) sendBit(tx[b], rx[b]);
  endtask

  task automatic sel();
    @(negedge clk); chipSelN = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); chipSelN = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdStat(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic rdMem(input logic [8:0] a, input int n, output logic [7:0] d [6]);
    logic [7:0] r;
    sel(); xfer(8'h03 | {4'b0, a[8], 3'b0}, r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(8'h00, d[i]);
    desel();
  endtask

  task automatic wrMem(input logic [8:0] a, input int n, input logic [7:0] d [6], input bit upd);
    logic [7:0] r;
    sel(); xfer(8'h02 | {4'b0, a[8], 3'b0}, r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xfer(d[i], r);
      if (upd) model[{a[8:2], 2'(a[1:0] + i)}] = d[i];
    end
    desel();
  endtask

  task automatic waitProg();
    repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic wrStat(input logic [7:0] v);
    logic [7:0] r;
    cmd(8'h06); sel(); xfer(8'h01, r); xfer(v, r); desel(); waitProg();
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [7:0] d [6];
    chk("R1 dout idle", {7'b0, serDout}, 8'h00);
    rdStat(s); chk("R1/R8 reset status", s, 8'h00);
    rdMem(9'h000, 2, d); chk("R1/R2 erased byte0", d[0], 8'hFF); chk("R1 erased byte1", d[1], 8'hFF);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd(8'h06); rdStat(s); chk("R4 latch set", s, 8'h02);
    cmd(8'h04); rdStat(s); chk("R4 latch cleared", s, 8'h00);
  endtask

  task automatic t_byteWrite();
    logic [7:0] s; logic [7:0] d [6];
    d[0] = 8'hA5;
    cmd(8'h06); wrMem(9'h1FE, 1, d, 1);
    rdStat(s); chk("R8 busy status", s, 8'h03);
    waitProg(); rdStat(s); chk("R5 latch cleared after cycle", s, 8'h00);
    rdMem(9'h1FE, 1, d); chk("R3/R2 byte written", d[0], 8'hA5);
  endtask

  task automatic t_pageWrap();
    logic [7:0] d [6]; logic [7:0] q [6];
    for (int i = 0; i < 6; i++) d[i] = 8'h40 + 8'(i * 7);
    cmd(8'h06); wrMem(9'h012, 6, d, 1); waitProg();
    rdMem(9'h010, 4, q);
    for (int i = 0; i < 4; i++) chk("R9 page slot", q[i], model[9'h010 + 9'(i)]);
  endtask

  task automatic t_readWrap();
    logic [7:0] d [6]; logic [7:0] q [6];
    for (int i = 0; i < 4; i++) d[i] = 8'hC0 + 8'(i);
    cmd(8'h06); wrMem(9'h1FC, 4, d, 1); waitProg();
    rdMem(9'h1FD, 4, q);
    chk("R10 read 1FD", q[0], model[9'h1FD]); chk("R10 read 1FE", q[1], model[9'h1FE]);
    chk("R10 read 1FF", q[2], model[9'h1FF]); chk("R10 wrap to 000", q[3], model[9'h000]);
  endtask

  task automatic t_noWel();
    logic [7:0] s; logic [7:0] d [6];
    d[0] = 8'h5A; wrMem(9'h060, 1, d, 0);
    rdStat(s); chk("R4 no cycle without latch", s, 8'h00);
    rdMem(9'h060, 1, d); chk("R4 byte unchanged", d[0], model[9'h060]);
  endtask

  task automatic t_guard();
    logic [7:0] s; logic [7:0] d [6];
    wrAllow = 1'b0; d[0] = 8'h77;
    cmd(8'h06); wrMem(9'h040, 1, d, 0);
    rdStat(s); chk("R6 guard low keeps latch, no busy", s, 8'h02);
    rdMem(9'h040, 1, d); chk("R6 byte unchanged", d[0], model[9'h040]);
    cmd(8'h04); wrAllow = 1'b1;
  endtask

  task automatic t_abort();
    logic [7:0] s, r; logic [7:0] d [6]; logic b;
    cmd(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h50, r); xfer(8'h99, r);
    for (int i = 0; i < 3; i++) sendBit(1'b1, b);
    desel();
    rdStat(s); chk("R3 aborted frame no cycle", s, 8'h02);
    rdMem(9'h050, 1, d); chk("R3 aborted byte unchanged", d[0], model[9'h050]);
    cmd(8'h04);
  endtask

  task automatic t_busyIgnore();
    logic [7:0] s; logic [7:0] d [6];
    d[0] = 8'h3C;
    cmd(8'h06); wrMem(9'h020, 1, d, 1);
    cmd(8'h04);
    rdStat(s); chk("R13 clear ignored while busy", s, 8'h03);
    waitProg(); rdStat(s); chk("R5 idle after cycle", s, 8'h00);
    rdMem(9'h020, 1, d); chk("R13 write completed", d[0], 8'h3C);
  endtask

  task automatic t_protect();
    logic [7:0] s; logic [7:0] d [6];
    wrStat(8'h04); rdStat(s); chk("R11 level 01 stored", s, 8'h04);
    d[0] = 8'h11; cmd(8'h06); wrMem(9'h180, 1, d, 0);
    rdStat(s); chk("R12 level01 blocks 180", s, 8'h06);
    d[0] = 8'h22; wrMem(9'h17C, 1, d, 1); waitProg();
    rdMem(9'h17C, 1, d); chk("R12 level01 allows 17C", d[0], 8'h22);
    rdMem(9'h180, 1, d); chk("R12 180 unchanged", d[0], model[9'h180]);
    wrStat(8'h08);
    d[0] = 8'h33; cmd(8'h06); wrMem(9'h100, 1, d, 0);
    rdStat(s); chk("R12 level10 blocks 100", s, 8'h0A);
    d[0] = 8'h44; wrMem(9'h0FC, 1, d, 1); waitProg();
    rdMem(9'h0FC, 1, d); chk("R12 level10 allows 0FC", d[0], 8'h44);
    wrStat(8'h0C);
    d[0] = 8'h55; cmd(8'h06); wrMem(9'h000, 1, d, 0);
    rdStat(s); chk("R12 level11 blocks 000", s, 8'h0E);
    cmd(8'h04); wrStat(8'h00); rdStat(s); chk("R11 level back to 00", s, 8'h00);
  endtask

  task automatic t_pause();
    logic [7:0] r; logic [7:0] q [6]; logic b;
    sel(); xfer(8'h03, r);
    for (int i = 7; i >= 4; i--) sendBit(1'(8'h10 >> i), b);
    @(negedge clk); pauseN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); serDin = 1'b1; serClk = 1'b1;
      repeat (HALF) @(negedge clk); serClk = 1'b0; repeat (HALF) @(negedge clk);
    end
    pauseN = 1'b1;
    for (int i = 3; i >= 0; i--) sendBit(1'(8'h10 >> i), b);
    xfer(8'h00, q[0]); xfer(8'h00, q[1]); desel();
    chk("R7 paused frame byte 010", q[0], model[9'h010]);
    chk("R7 paused frame byte 011", q[1], model[9'h011]);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk); rstN = 1'b1; repeat (2) @(negedge clk);
    t_reset(); t_wel(); t_byteWrite(); t_pageWrap(); t_readWrap();
    t_noWel(); t_guard(); t_abort(); t_busyIgnore(); t_protect(); t_pause();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1; nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule